// File: doc/BRIEF.md
# PCM Codec Serial Time-Slot Port

This block is the digital half of a telephony codec's serial port. Every system clock it samples the slow serial pins: two bit clocks, two frame syncs, the receive data line and the receive master-clock pin. On the transmit side, a frame-sync leading edge loads one sample byte from a parallel valid/ready input. The next eight rising edges of the transmit bit clock each put one bit on the data output, most significant bit first. While those bits are out, the output enable is high and an active-low time-slot strobe is held low. At all other times the output is released, so the pad is high impedance.

On the receive side, a frame-sync leading edge arms a capture. The next eight falling edges of the receive bit clock each sample the data line, most significant bit first. The finished byte appears on a parallel output with a one-cycle valid pulse. The receive master-clock pin is also watched as a static mode input. If it stays low long enough, the block reports that the transmit master clock should drive all timing. If it stays high long enough, the block powers down its serial port. Any later toggle restores normal operation.

Streaming rules: `tx_ready` is a single-cycle pulse at each transmit frame-sync leading edge. The byte is taken only in a cycle where `tx_valid` and `tx_ready` are both high. The producer must hold `tx_valid` and `tx_data` steady across the frame-sync edge. If no byte is offered at that edge, the idle byte is sent. The receive output has no back-pressure, because the serial line cannot be stalled. The consumer must take `rx_data` in the `rx_valid` cycle, and the next byte overwrites it.

Top module: `pcm_slot_port`

## Requirements
- R1: After reset, `dx_oe`=0, `ts_n`=1, `rx_valid`=0, `tx_ready`=0, `use_tx_mclk`=0 and `pwr_down`=0.
- R2: After a `fs_tx` leading edge, the next 8 rising edges of `bclk_tx` each drive one bit of the loaded byte on `dx_o` with `dx_oe`=1, bit 7 first and bit 0 last. The 9th rising edge sets `dx_oe` to 0.
- R3: `ts_n` is 0 exactly in the cycles where `dx_oe` is 1, and 1 otherwise.
- R4: `tx_ready` pulses for one cycle at each `fs_tx` leading edge. The byte sent is `tx_data` when `tx_valid` is high in that cycle, and IDLE_BYTE (default 8'hFF) otherwise.
- R5: After a `fs_rx` leading edge, `dr` is sampled on the next 8 falling edges of `bclk_rx`, the first sample being bit 7. After the 8th sample, `rx_data` holds the byte and `rx_valid` is high for exactly one cycle.
- R6: If the synchronized `mclk_rx` shows no transition for STATIC_CYC (32) system cycles while low, `use_tx_mclk` becomes 1. It is 0 before that point and returns to 0 after any toggle.
- R7: If `mclk_rx` stays high under the same rule, `pwr_down` becomes 1. A toggle returns it to 0. `pwr_down` and `use_tx_mclk` are never both 1.
- R8: While `pwr_down`=1, `dx_oe` stays 0, `ts_n` stays 1, `tx_ready` and `rx_valid` stay 0, and any slot in progress is abandoned.
- R9: Transfers are correct for any bit clock whose high and low phases each last at least 3 system clock cycles. This spans rates from 64 kHz to 2.048 MHz against a fast system clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clocks |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_data | input | 8 | Byte to transmit in the next slot |
| tx_valid | input | 1 | tx_data is offered |
| tx_ready | output | 1 | One-cycle accept pulse at the transmit frame-sync edge |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle pulse when rx_data is new |
| bclk_tx | input | 1 | Transmit bit clock |
| fs_tx | input | 1 | Transmit frame sync |
| dx_o | output | 1 | Serial transmit data to the pad |
| dx_oe | output | 1 | Pad output enable (0 = high impedance) |
| ts_n | output | 1 | Active-low transmit time-slot strobe |
| bclk_rx | input | 1 | Receive bit clock |
| fs_rx | input | 1 | Receive frame sync |
| dr | input | 1 | Serial receive data |
| mclk_rx | input | 1 | Receive master-clock pin, watched for static levels |
| use_tx_mclk | output | 1 | Pin held low: transmit master clock selected |
| pwr_down | output | 1 | Pin held high: port powered down |

## Verification
The bench builds the block with its default parameters: 8-bit slots, two synchronizer stages and a 32-cycle static window. With 8-bit slots, every one of the 256 byte values can be sent and received. The sweep alternates bit-clock phases of 3 and 5 system cycles, which reaches both the fastest supported bit clock and a slower one. The 32-cycle window is short enough to probe the mode detector both before and after its threshold. It also allows whole frames to run during power-down.

// File: rtl/pcm_slot_pkg.sv
package pcm_slot_pkg;
  typedef enum logic [1:0] {
    MC_RUN   = 2'd0,
    MC_TXCLK = 2'd1,
    MC_PDN   = 2'd2
  } mclk_mode_t;
endpackage

// File: rtl/pcm_pin_sync.sv
module pcm_pin_sync #(
  parameter int W      = 6,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n) stage_q[s] <= '0;
        else if (s == 0) stage_q[s] <= d;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/pcm_tx_slot.sv
module pcm_tx_slot #(
  parameter int          W         = 8,
  parameter logic [W-1:0] IDLE_BYTE = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fs_s,
  input  logic         bclk_s,
  input  logic         pdn,
  input  logic [W-1:0] tx_data,
  input  logic         tx_valid,
  output logic         tx_ready,
  output logic         dx_o,
  output logic         dx_oe,
  output logic         ts_n
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;

  logic          fs_q, bclk_q;
  logic          fs_rise, bclk_rise;
  logic          armed, active;
  logic [CW-1:0] cnt;
  logic [W-1:0]  sh;

  assign fs_rise   = fs_s && !fs_q;
  assign bclk_rise = bclk_s && !bclk_q;
  assign tx_ready  = fs_rise && !pdn;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fs_q   <= 1'b0;
      bclk_q <= 1'b0;
      armed  <= 1'b0;
      active <= 1'b0;
      cnt    <= '0;
      sh     <= '0;
      dx_o   <= 1'b0;
      dx_oe  <= 1'b0;
      ts_n   <= 1'b1;
    end else begin
      fs_q   <= fs_s;
      bclk_q <= bclk_s;
      if (pdn) begin
        armed  <= 1'b0;
        active <= 1'b0;
        dx_oe  <= 1'b0;
        ts_n   <= 1'b1;
      end else if (fs_rise) begin
        sh     <= tx_valid ? tx_data : IDLE_BYTE;
        armed  <= 1'b1;
        active <= 1'b0;
        dx_oe  <= 1'b0;
        ts_n   <= 1'b1;
      end else if (bclk_rise) begin
        if (armed && !active) begin
          active <= 1'b1;
          cnt    <= '0;
          dx_o   <= sh[W-1];
          sh     <= sh << 1;
          dx_oe  <= 1'b1;
          ts_n   <= 1'b0;
        end else if (active) begin
          if (cnt == CW'(W-1)) begin
            active <= 1'b0;
            armed  <= 1'b0;
            dx_oe  <= 1'b0;
            ts_n   <= 1'b1;
          end else begin
            cnt  <= cnt + CW'(1);
            dx_o <= sh[W-1];
            sh   <= sh << 1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/pcm_rx_slot.sv
module pcm_rx_slot #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fs_s,
  input  logic         bclk_s,
  input  logic         dr_s,
  input  logic         pdn,
  output logic [W-1:0] rx_data,
  output logic         rx_valid
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;

  logic          fs_q, bclk_q;
  logic          fs_rise, bclk_fall;
  logic          armed;
  logic [CW-1:0] cnt;
  logic [W-2:0]  sh;

  assign fs_rise   = fs_s && !fs_q;
  assign bclk_fall = !bclk_s && bclk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fs_q     <= 1'b0;
      bclk_q   <= 1'b0;
      armed    <= 1'b0;
      cnt      <= '0;
      sh       <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else begin
      fs_q     <= fs_s;
      bclk_q   <= bclk_s;
      rx_valid <= 1'b0;
      if (pdn) begin
        armed <= 1'b0;
      end else if (fs_rise) begin
        armed <= 1'b1;
        cnt   <= '0;
      end else if (bclk_fall && armed) begin
        sh <= {sh[W-3:0], dr_s};
        if (cnt == CW'(W-1)) begin
          rx_data  <= {sh, dr_s};
          rx_valid <= 1'b1;
          armed    <= 1'b0;
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/pcm_mclk_watch.sv
module pcm_mclk_watch
  import pcm_slot_pkg::*;
#(
  parameter int STATIC_CYC = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_s,
  output mclk_mode_t mode
);
  localparam int SW = $clog2(STATIC_CYC + 1);

  logic          prev;
  logic [SW-1:0] quiet;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev  <= 1'b0;
      quiet <= '0;
      mode  <= MC_RUN;
    end else begin
      prev <= pin_s;
      if (pin_s != prev) begin
        quiet <= '0;
        mode  <= MC_RUN;
      end else if (quiet != SW'(STATIC_CYC)) begin
        quiet <= quiet + SW'(1);
      end else begin
        mode <= prev ? MC_PDN : MC_TXCLK;
      end
    end
  end
endmodule

// File: rtl/pcm_slot_port.sv
module pcm_slot_port
  import pcm_slot_pkg::*;
#(
  parameter int           W           = 8,
  parameter int           SYNC_STAGES = 2,
  parameter int           STATIC_CYC  = 32,
  parameter logic [W-1:0] IDLE_BYTE   = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] tx_data,
  input  logic         tx_valid,
  output logic         tx_ready,
  output logic [W-1:0] rx_data,
  output logic         rx_valid,
  input  logic         bclk_tx,
  input  logic         fs_tx,
  output logic         dx_o,
  output logic         dx_oe,
  output logic         ts_n,
  input  logic         bclk_rx,
  input  logic         fs_rx,
  input  logic         dr,
  input  logic         mclk_rx,
  output logic         use_tx_mclk,
  output logic         pwr_down
);
  localparam int NPIN = 6;

  logic [NPIN-1:0] pins_raw, pins_s;
  mclk_mode_t      mode;
  logic            pdn;

  assign pins_raw = {mclk_rx, dr, fs_rx, bclk_rx, fs_tx, bclk_tx};

  pcm_pin_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pins_raw), .q(pins_s)
  );

  pcm_mclk_watch #(.STATIC_CYC(STATIC_CYC)) u_watch (
    .clk(clk), .rst_n(rst_n), .pin_s(pins_s[5]), .mode(mode)
  );

  assign pdn         = (mode == MC_PDN);
  assign pwr_down    = pdn;
  assign use_tx_mclk = (mode == MC_TXCLK);

  pcm_tx_slot #(.W(W), .IDLE_BYTE(IDLE_BYTE)) u_tx (
    .clk(clk), .rst_n(rst_n), .fs_s(pins_s[1]), .bclk_s(pins_s[0]), .pdn(pdn),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .dx_o(dx_o), .dx_oe(dx_oe), .ts_n(ts_n)
  );

  pcm_rx_slot #(.W(W)) u_rx (
    .clk(clk), .rst_n(rst_n), .fs_s(pins_s[3]), .bclk_s(pins_s[2]),
    .dr_s(pins_s[4]), .pdn(pdn), .rx_data(rx_data), .rx_valid(rx_valid)
  );
endmodule

// File: rtl/pcm_slot_port_chk.sv
module pcm_slot_port_chk (
  input logic clk,
  input logic rst_n,
  input logic dx_oe,
  input logic ts_n,
  input logic rx_valid,
  input logic tx_ready,
  input logic use_tx_mclk,
  input logic pwr_down
);
  p_strobe_tracks_oe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ts_n == !dx_oe);

  p_ready_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |=> !tx_ready);

  p_rx_pulse_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  p_modes_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(pwr_down && use_tx_mclk));

  p_pdn_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |=> (!dx_oe && ts_n && !rx_valid && !tx_ready));
endmodule

bind pcm_slot_port pcm_slot_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .dx_oe(dx_oe), .ts_n(ts_n), .rx_valid(rx_valid),
  .tx_ready(tx_ready), .use_tx_mclk(use_tx_mclk), .pwr_down(pwr_down)
);

// File: tb/pcm_slot_port_test.sv
module pcm_slot_port_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] tx_data = '0;
  logic       tx_valid = 1'b0;
  logic       tx_ready;
  logic [7:0] rx_data;
  logic       rx_valid;
  logic       bclk_tx = 1'b0, fs_tx = 1'b0, dx_o, dx_oe, ts_n;
  logic       bclk_rx = 1'b0, fs_rx = 1'b0, dr = 1'b0;
  logic       mclk_rx = 1'b0, use_tx_mclk, pwr_down;

  logic mclk_run = 1'b1, mclk_lvl = 1'b0, div = 1'b0;
  int   errors = 0, checks = 0;
  bit   done = 1'b0;

  int         rx_pulses = 0, ready_cnt = 0, accept_cnt = 0;
  logic [7:0] rx_last = '0;
  bit         oe_seen = 1'b0, ts_low_seen = 1'b0;

  always #5 clk = ~clk;

  pcm_slot_port uut (
    .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid),
    .bclk_tx(bclk_tx), .fs_tx(fs_tx), .dx_o(dx_o), .dx_oe(dx_oe), .ts_n(ts_n),
    .bclk_rx(bclk_rx), .fs_rx(fs_rx), .dr(dr), .mclk_rx(mclk_rx),
    .use_tx_mclk(use_tx_mclk), .pwr_down(pwr_down)
  );

  always @(negedge clk) begin
    if (mclk_run) begin
      div <= !div;
      if (div) mclk_rx <= !mclk_rx;
    end else mclk_rx <= mclk_lvl;
    if (rx_valid) begin rx_pulses <= rx_pulses + 1; rx_last <= rx_data; end
    if (tx_ready) ready_cnt <= ready_cnt + 1;
    if (tx_ready && tx_valid) accept_cnt <= accept_cnt + 1;
    if (dx_oe) oe_seen <= 1'b1;
    if (!ts_n) ts_low_seen <= 1'b1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    @(negedge clk);
    rx_pulses = 0; ready_cnt = 0; accept_cnt = 0;
    oe_seen = 1'b0; ts_low_seen = 1'b0;
  endtask

  // Sends one transmit slot; returns the collected byte and slot flags.
  task automatic tx_frame(input logic [7:0] b, input bit vld, input int ph,
                          output logic [7:0] got, output bit shape_ok);
    got = '0; shape_ok = 1'b1;
    tx_data = b; tx_valid = vld; fs_tx = 1'b1;
    repeat (4) @(negedge clk);
    for (int k = 0; k < 9; k++) begin
      bclk_tx = 1'b1;
      repeat (ph) @(negedge clk);
      if (k < 8) begin
        got = {got[6:0], dx_o};
        if (!dx_oe || ts_n) shape_ok = 1'b0;
      end else if (dx_oe || !ts_n) shape_ok = 1'b0;
      if (k == 0) begin fs_tx = 1'b0; tx_valid = 1'b0; end
      bclk_tx = 1'b0;
      repeat (ph) @(negedge clk);
    end
  endtask

  task automatic rx_frame(input logic [7:0] b, input int ph);
    fs_rx = 1'b1;
    repeat (4) @(negedge clk);
    for (int k = 7; k >= 0; k--) begin
      dr = b[k];
      bclk_rx = 1'b1;
      repeat (ph) @(negedge clk);
      bclk_rx = 1'b0;
      fs_rx = 1'b0;
      repeat (ph) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] got;
    bit         shape;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!dx_oe && ts_n && !rx_valid && !tx_ready && !use_tx_mclk && !pwr_down,
        "R1 reset outputs", {dx_oe, ts_n, rx_valid, tx_ready, use_tx_mclk, pwr_down},
        6'b010000);

    // R2 R3 R4 R9: every byte value, bit phases 3 and 5
    for (int v = 0; v < 256; v++) begin
      int ph = v[0] ? 3 : 5;
      clear_mon();
      tx_frame(8'(v), 1'b1, ph, got, shape);
      chk(got == 8'(v), "R2 R9 tx byte", got, v);
      chk(shape, "R3 strobe and enable over slot", shape, 1);
      chk(ready_cnt == 1 && accept_cnt == 1, "R4 one accept per frame",
          ready_cnt * 16 + accept_cnt, 17);
    end

    // R4: no byte offered sends the idle byte
    clear_mon();
    tx_frame(8'h3C, 1'b0, 4, got, shape);
    chk(got == 8'hFF && shape, "R4 idle byte", got, 8'hFF);
    chk(ready_cnt == 1 && accept_cnt == 0, "R4 ready without valid", accept_cnt, 0);

    // R5 R9: every byte value received
    for (int v = 0; v < 256; v++) begin
      int ph = v[1] ? 3 : 5;
      clear_mon();
      rx_frame(8'(v), ph);
      chk(rx_pulses == 1, "R5 single rx pulse", rx_pulses, 1);
      chk(rx_last == 8'(v), "R5 R9 rx byte", rx_last, v);
    end

    // R6: static low selects transmit master clock
    mclk_run = 1'b0; mclk_lvl = 1'b0;
    repeat (20) @(negedge clk);
    chk(!use_tx_mclk, "R6 not static before window", use_tx_mclk, 0);
    repeat (30) @(negedge clk);
    chk(use_tx_mclk && !pwr_down, "R6 static low", {use_tx_mclk, pwr_down}, 2'b10);
    mclk_run = 1'b1;
    repeat (10) @(negedge clk);
    chk(!use_tx_mclk, "R6 toggle restores", use_tx_mclk, 0);

    // R7 R8: static high powers down
    mclk_run = 1'b0; mclk_lvl = 1'b1;
    repeat (50) @(negedge clk);
    chk(pwr_down && !use_tx_mclk, "R7 static high", {pwr_down, use_tx_mclk}, 2'b10);
    clear_mon();
    tx_frame(8'h00, 1'b1, 4, got, shape);
    rx_frame(8'hA5, 4);
    chk(!oe_seen && !ts_low_seen, "R8 transmit silent in power-down",
        {oe_seen, ts_low_seen}, 0);
    chk(rx_pulses == 0 && ready_cnt == 0, "R8 no rx valid or ready in power-down",
        rx_pulses + ready_cnt, 0);
    mclk_run = 1'b1;
    repeat (10) @(negedge clk);
    chk(!pwr_down, "R7 toggle leaves power-down", pwr_down, 0);

    clear_mon();
    tx_frame(8'h5A, 1'b1, 3, got, shape);
    chk(got == 8'h5A && shape, "R2 after power-down", got, 8'h5A);
    rx_frame(8'hC3, 3);
    chk(rx_pulses == 1 && rx_last == 8'hC3, "R5 after power-down", rx_last, 8'hC3);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule